// File: doc/BRIEF.md
# Averaging Single-Shot Converter Channel Sequencer

The block runs conversions for four logical channels, A to D, that share a single analog-to-digital converter. Each channel holds two 32-bit setup words. The first word carries the run flag, the one-shot flag, the averaging flag and the physical input number. The second word carries the averaging depth. A channel whose run flag is set asks the converter for samples of its chosen input. It sums 4, 8, 16 or 32 of them, or takes a single sample when averaging is off. It then posts one 12-bit result for one cycle. In one-shot mode it clears its own run flag once the result is out.

Setup words are written through a simple write strobe with a byte offset. A fixed-priority arbiter gives the converter to one channel per conversion, with A first and D last. Only one conversion is outstanding at any time. Clearing a channel's run flag stops it at once. A conversion that is already in flight for that channel is then thrown away when its data returns.

Top module: `adc_avg_seq`

## Requirements
- R1: After reset, chan_en, cnv_start and res_valid are all 0.
- R2: Channel n's first word is at offset n*0x20 and its second word at n*0x20+0x10. A write whose offset has any of bits 3:0 set, or any bit above bit 6 set, changes nothing. In the first word, bit 31 is the run flag, bit 30 the one-shot flag, bit 29 the averaging flag, and bits 27:24 the physical input driven on cnv_input.
- R3: cnv_start is a one-cycle pulse. It fires the cycle after the arbiter finds a requesting channel while no conversion is outstanding. No new cnv_start comes before the cycle after cnv_done returns for the outstanding request.
- R4: With averaging on, bits 13:12 of the second word select N = 4, 8, 16 or 32 samples (codes 0 to 3). The result is the truncated sum of the N samples divided by N, and all-ones inputs give 0xFFF.
- R5: With averaging off, the channel converts exactly once and posts the raw sample.
- R6: res_valid is high for one cycle, the cycle after the edge that samples the final cnv_done, with res_ch naming the channel. In one-shot mode, the channel's chan_en bit is already 0 in that cycle and no further conversion starts.
- R7: With the one-shot flag at 0, the channel stays enabled after each result and starts the next batch.
- R8: When several channels request, the converter is granted to the lowest-lettered one (A before B before C before D). Arbitration happens again before each single conversion.
- R9: Writing the first word with the run flag at 0 disables the channel in the next cycle. Data returning for an already-started conversion is discarded, with no result and no new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Setup word write strobe |
| cfg_addr | input | 8 | Byte offset of the setup word |
| cfg_wdata | input | 32 | Setup word data |
| chan_en | output | 4 | Run flag of each channel, bit 0 = A |
| cnv_start | output | 1 | Conversion request pulse |
| cnv_input | output | 4 | Physical input to convert |
| cnv_done | input | 1 | Converter data valid pulse |
| cnv_data | input | 12 | Converter sample |
| res_valid | output | 1 | Result pulse |
| res_ch | output | 2 | Channel that produced the result |
| res_data | output | 12 | Averaged or single result |

## Verification
A write lands at the next clock edge, and the first cnv_start is visible in the cycle after that edge. The result appears exactly one cycle after the edge that samples the final cnv_done. The cleared run flag of a one-shot channel is visible in that same cycle. The bench's converter model records the cycle in which it drives each cnv_done. It then requires res_valid to appear exactly one cycle later, and reads chan_en at that point. All outputs are read one nanosecond after a falling edge, so every registered change has settled and no edge race can occur.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;
  // setup word field positions (decoded by software, so they are fixed)
  localparam int CFG_W      = 32;
  localparam int RUN_BIT    = 31;
  localparam int ONCE_BIT   = 30;
  localparam int AVG_BIT    = 29;
  localparam int INSEL_LSB  = 24;
  localparam int DEPTH_LSB  = 12;
  localparam int DEPTH_W    = 2;
  localparam int MIN_SHIFT  = 2;
  localparam int MAX_SHIFT  = MIN_SHIFT + (1 << DEPTH_W) - 1;

  // number of samples summed for a depth code
  function automatic int depth_samples(logic [DEPTH_W-1:0] code);
    return 1 << (MIN_SHIFT + int'(code));
  endfunction

  // right shift that turns the sum into the mean
  function automatic int depth_shift(logic [DEPTH_W-1:0] code);
    return MIN_SHIFT + int'(code);
  endfunction
endpackage

// File: rtl/adc_seq_arb.sv
`timescale 1ns/1ps
module adc_seq_arb #(
  parameter int NUM_CH = 4
) (
  input  logic [NUM_CH-1:0] req,
  output logic [NUM_CH-1:0] grant,
  output logic              any_req
);
  always_comb begin
    grant = '0;
    // descending walk: the lowest requesting index is written last and wins
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (req[i]) grant = NUM_CH'(1) << i;
    end
    any_req = |req;
  end

  always_comb begin
    AST_GRANT_ONEHOT: assert ($onehot0(grant)); // R8
    AST_GRANT_IFF_REQ: assert ((|grant) == (|req)); // R8
  end
endmodule

// File: rtl/adc_seq_chan.sv
`timescale 1ns/1ps
module adc_seq_chan
  import adc_seq_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_word1,
  input  logic              wr_word2,
  input  logic [CFG_W-1:0]  wdata,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  output logic              req,
  output logic [SEL_W-1:0]  sel,
  output logic              enabled,
  output logic              res_post,
  output logic [DATA_W-1:0] res_val
);
  localparam int CNT_W = MAX_SHIFT + 1;
  localparam int ACC_W = DATA_W + MAX_SHIFT;

  logic               run_q, once_q, avg_q;
  logic [DEPTH_W-1:0] depth_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [ACC_W-1:0]   acc_q;

  // internal events brought out for the assertions
  logic              take;
  logic              last;
  logic [ACC_W-1:0]  sum;
  logic [DATA_W-1:0] mean;
  int                target;

  always_comb begin
    target = avg_q ? depth_samples(depth_q) : 1;
    take   = smp_valid & run_q;
    last   = (int'(cnt_q) + 1) >= target;
    sum    = acc_q + ACC_W'(smp_data);
    mean   = avg_q ? DATA_W'(sum >> depth_shift(depth_q)) : smp_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      once_q   <= 1'b0;
      avg_q    <= 1'b0;
      sel      <= '0;
      depth_q  <= '0;
      cnt_q    <= '0;
      acc_q    <= '0;
      res_post <= 1'b0;
      res_val  <= '0;
    end else begin
      res_post <= 1'b0;
      if (wr_word1) begin
        run_q  <= wdata[RUN_BIT];
        once_q <= wdata[ONCE_BIT];
        avg_q  <= wdata[AVG_BIT];
        sel    <= wdata[INSEL_LSB +: SEL_W];
        cnt_q  <= '0;
        acc_q  <= '0;
      end else if (take) begin
        if (last) begin
          res_post <= 1'b1;
          res_val  <= mean;
          cnt_q    <= '0;
          acc_q    <= '0;
          if (once_q) run_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
          acc_q <= sum;
        end
      end
      if (wr_word2) depth_q <= wdata[DEPTH_LSB +: DEPTH_W];
    end
  end

  assign req     = run_q;
  assign enabled = run_q;

  AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    res_post && once_q |-> !run_q); // R6
  AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (cnt_q == '0) && (acc_q == '0)); // R9
  AST_STOP_NO_POST: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q && !wr_word1 |=> !res_post); // R9
endmodule

// File: rtl/adc_avg_seq.sv
`timescale 1ns/1ps
module adc_avg_seq
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 12,
  parameter int SEL_W  = 4,
  parameter int ADDR_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_wr,
  input  logic [ADDR_W-1:0]          cfg_addr,
  input  logic [CFG_W-1:0]           cfg_wdata,
  output logic [NUM_CH-1:0]          chan_en,
  output logic                       cnv_start,
  output logic [SEL_W-1:0]           cnv_input,
  input  logic                       cnv_done,
  input  logic [DATA_W-1:0]          cnv_data,
  output logic                       res_valid,
  output logic [$clog2(NUM_CH)-1:0]  res_ch,
  output logic [DATA_W-1:0]          res_data
);
  localparam int CH_W   = $clog2(NUM_CH);
  localparam int CH_LSB = 5;                 // 0x20 spacing per channel
  localparam int W2_BIT = 4;                 // second word at +0x10
  localparam logic [CFG_W-1:0] USED_MASK =
    (CFG_W'(1) << RUN_BIT) | (CFG_W'(1) << ONCE_BIT) | (CFG_W'(1) << AVG_BIT) |
    (((CFG_W'(1) << SEL_W) - 1) << INSEL_LSB) |
    (((CFG_W'(1) << DEPTH_W) - 1) << DEPTH_LSB);

  logic              addr_ok;
  logic [CH_W-1:0]   wr_ch;
  logic              wr_is_w2;
  logic              cfg_unused;

  logic [NUM_CH-1:0] req, grant, post, smp_valid;
  logic              any_req;
  logic [SEL_W-1:0]  sel_arr  [NUM_CH];
  logic [DATA_W-1:0] rval_arr [NUM_CH];
  logic              busy_q;
  logic [CH_W-1:0]   owner_q, grant_idx;

  assign addr_ok  = (cfg_addr[3:0] == '0) && (cfg_addr[ADDR_W-1:CH_LSB+CH_W] == '0);
  assign wr_ch    = cfg_addr[CH_LSB +: CH_W];
  assign wr_is_w2 = cfg_addr[W2_BIT];
  assign cfg_unused = ^(cfg_wdata & ~USED_MASK);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    assign smp_valid[g] = cnv_done & busy_q & (owner_q == CH_W'(g));
    adc_seq_chan #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_word1  (cfg_wr & addr_ok & (wr_ch == CH_W'(g)) & !wr_is_w2),
      .wr_word2  (cfg_wr & addr_ok & (wr_ch == CH_W'(g)) &  wr_is_w2),
      .wdata     (cfg_wdata),
      .smp_valid (smp_valid[g]),
      .smp_data  (cnv_data),
      .req       (req[g]),
      .sel       (sel_arr[g]),
      .enabled   (chan_en[g]),
      .res_post  (post[g]),
      .res_val   (rval_arr[g])
    );
  end

  adc_seq_arb #(.NUM_CH(NUM_CH)) u_arb (
    .req     (req),
    .grant   (grant),
    .any_req (any_req)
  );

  always_comb begin
    cnv_input = '0;
    grant_idx = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (grant[i]) begin
        cnv_input = sel_arr[i];
        grant_idx = CH_W'(i);
      end
    end
  end

  assign cnv_start = !busy_q & any_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      owner_q <= '0;
    end else if (cnv_start) begin
      busy_q  <= 1'b1;
      owner_q <= grant_idx;
    end else if (cnv_done && busy_q) begin
      busy_q  <= 1'b0;
    end
  end

  always_comb begin
    res_valid = |post;
    res_ch    = '0;
    res_data  = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (post[i]) begin
        res_ch   = CH_W'(i);
        res_data = rval_arr[i];
      end
    end
  end

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_start |=> !cnv_start); // R3
  AST_START_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_start |=> busy_q); // R3
  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_done && busy_q |=> !busy_q); // R3
  AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R6
  AST_ONE_POSTER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(post)); // R6
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !res_valid); // R1
endmodule

// File: tb/test_adc_avg_seq.sv
`timescale 1ns/1ps
module test_adc_avg_seq;
  localparam int CLK_NS = 10;
  localparam int LAT    = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [3:0]  chan_en;
  logic        cnv_start;
  logic [3:0]  cnv_input;
  logic        cnv_done = 1'b0;
  logic [11:0] cnv_data = '0;
  logic        res_valid;
  logic [1:0]  res_ch;
  logic [11:0] res_data;

  adc_avg_seq i_adc_avg_seq (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .chan_en(chan_en), .cnv_start(cnv_start),
    .cnv_input(cnv_input), .cnv_done(cnv_done), .cnv_data(cnv_data),
    .res_valid(res_valid), .res_ch(res_ch), .res_data(res_data)
  );

  initial forever #(CLK_NS/2) clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;
  bit hold = 0, force_max = 0;
  int seq [16];
  bit pend = 0;
  int pend_in = 0, lat_left = 0, done_cyc = -10, viol = 0;
  int log_in [64];
  int log_n = 0;

  initial forever begin @(posedge clk); cyc++; end

  function automatic int smp(int inp, int k);
    if (force_max) return 4095;
    return (inp * 200 + k * 37 + 11) % 4096;
  endfunction

  function automatic int exp_avg(int inp, int k0, int n);
    int s = 0;
    for (int k = k0; k < k0 + n; k++) s += smp(inp, k);
    return s / n;
  endfunction

  function automatic logic [31:0] w1(bit run, bit once, bit avg, int inp);
    return (32'(run) << 31) | (32'(once) << 30) | (32'(avg) << 29) | (32'(inp & 15) << 24);
  endfunction

  // converter model: answers each request LAT falling edges later
  initial begin
    for (int i = 0; i < 16; i++) seq[i] = 0;
    forever begin
      @(negedge clk);
      cnv_done = 1'b0;
      if (pend && !hold) begin
        if (lat_left > 1) lat_left--;
        else begin
          cnv_done = 1'b1;
          cnv_data = 12'(smp(pend_in, seq[pend_in]));
          seq[pend_in]++;
          pend = 0;
          done_cyc = cyc;
        end
      end
      if (cnv_start) begin
        if (pend) viol++;
        pend = 1;
        pend_in = int'(cnv_input);
        lat_left = LAT;
        if (log_n < 64) log_in[log_n] = pend_in;
        log_n++;
      end
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 8'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    #1;
  endtask

  task automatic clear_seq();
    for (int i = 0; i < 16; i++) seq[i] = 0;
    log_n = 0;
  endtask

  task automatic wait_res(output int d, output int c, output int rc, output bit ok);
    ok = 0; d = 0; c = 0; rc = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk); #1;
      if (res_valid) begin
        d = int'(res_data); c = int'(res_ch); rc = cyc; ok = 1;
        return;
      end
    end
  endtask

  task automatic count_res(int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      if (res_valid) cnt++;
    end
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk(chan_en == 4'b0, "R1", "chan_en in reset", int'(chan_en), 0);
    chk(cnv_start == 1'b0, "R1", "cnv_start in reset", int'(cnv_start), 0);
    chk(res_valid == 1'b0, "R1", "res_valid in reset", int'(res_valid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk(chan_en == 4'b0 && !cnv_start, "R1", "idle after reset", int'(chan_en), 0);
  endtask

  task automatic t_single_avg(int ch, int code, int inp);
    int d, c, rc, n, e, n0; bit ok;
    clear_seq();
    n = 4 << code;
    wr(ch * 32 + 16, 32'(code) << 12);
    wr(ch * 32, w1(1, 1, 1, inp));
    wait_res(d, c, rc, ok);
    e = exp_avg(inp, 0, n);
    chk(ok, "R6", "result posted", int'(ok), 1);
    chk(d == e, "R4", "mean value", d, e);
    chk(c == ch, "R6", "res_ch", c, ch);
    chk(rc == done_cyc + 1, "R6", "result one cycle after last done", rc, done_cyc + 1);
    chk(chan_en[ch] == 1'b0, "R6", "one-shot run flag cleared", int'(chan_en[ch]), 0);
    chk(log_n == n, "R4", "samples requested", log_n, n);
    chk(log_in[0] == inp, "R2", "input select on cnv_input", log_in[0], inp);
    n0 = log_n;
    repeat (12) @(negedge clk);
    #1;
    chk(log_n == n0, "R6", "no start after one-shot", log_n, n0);
    chk(viol == 0, "R3", "single outstanding request", viol, 0);
  endtask

  task automatic t_no_avg();
    int d, c, rc; bit ok;
    clear_seq();
    wr(2 * 32 + 16, 32'(3) << 12);
    wr(2 * 32, w1(1, 1, 0, 7));
    wait_res(d, c, rc, ok);
    chk(d == smp(7, 0), "R5", "raw sample", d, smp(7, 0));
    chk(log_n == 1, "R5", "exactly one conversion", log_n, 1);
    chk(c == 2, "R5", "res_ch", c, 2);
  endtask

  task automatic t_full_scale();
    int d, c, rc; bit ok;
    clear_seq();
    force_max = 1;
    wr(3 * 32 + 16, 32'(3) << 12);
    wr(3 * 32, w1(1, 1, 1, 13));
    wait_res(d, c, rc, ok);
    chk(d == 4095, "R4", "full scale 32-sample mean", d, 4095);
    force_max = 0;
  endtask

  task automatic t_priority();
    int d, c, rc; bit ok;
    int exp_log [16];
    clear_seq();
    hold = 1;
    wr(3 * 32 + 16, 0); wr(3 * 32, w1(1, 1, 1, 4));
    wr(2 * 32 + 16, 0); wr(2 * 32, w1(1, 1, 1, 3));
    wr(1 * 32 + 16, 0); wr(1 * 32, w1(1, 1, 1, 2));
    wr(0 * 32 + 16, 0); wr(0 * 32, w1(1, 1, 1, 1));
    hold = 0;
    for (int r = 0; r < 4; r++) begin
      wait_res(d, c, rc, ok);
      chk(ok && c == r, "R8", "result order", c, r);
      chk(d == exp_avg(r + 1, 0, 4), "R8", "result value", d, exp_avg(r + 1, 0, 4));
    end
    exp_log[0] = 4;
    for (int i = 1; i < 13; i++) exp_log[i] = 1 + (i - 1) / 4;
    for (int i = 13; i < 16; i++) exp_log[i] = 4;
    chk(log_n == 16, "R8", "request count", log_n, 16);
    for (int i = 0; i < 16; i++)
      chk(log_in[i] == exp_log[i], "R8", "grant sequence entry", log_in[i], exp_log[i]);
  endtask

  task automatic t_continuous();
    int d, c, rc, cnt, n0; bit ok;
    clear_seq();
    wr(1 * 32 + 16, 0);
    wr(1 * 32, w1(1, 0, 1, 6));
    wait_res(d, c, rc, ok);
    chk(d == exp_avg(6, 0, 4), "R7", "first batch", d, exp_avg(6, 0, 4));
    chk(chan_en[1] == 1'b1, "R7", "stays enabled", int'(chan_en[1]), 1);
    wait_res(d, c, rc, ok);
    chk(ok && d == exp_avg(6, 4, 4), "R7", "second batch", d, exp_avg(6, 4, 4));
    wr(1 * 32, 0);
    chk(chan_en[1] == 1'b0, "R9", "disabled by write", int'(chan_en[1]), 0);
    count_res(10, cnt);
    n0 = log_n;
    begin
      int cnt2;
      count_res(20, cnt2);
      cnt += cnt2;
    end
    chk(cnt == 0, "R9", "no result after stop", cnt, 0);
    chk(log_n == n0, "R9", "no request after stop", log_n, n0);
  endtask

  task automatic t_stop_in_flight();
    int cnt;
    clear_seq();
    hold = 1;
    wr(16, 0);
    wr(0, w1(1, 1, 0, 9));
    repeat (3) @(negedge clk);
    #1;
    chk(log_n == 1, "R3", "request issued", log_n, 1);
    wr(0, 0);
    chk(chan_en[0] == 1'b0, "R9", "stopped while pending", int'(chan_en[0]), 0);
    hold = 0;
    count_res(20, cnt);
    chk(cnt == 0, "R9", "late data discarded", cnt, 0);
    chk(log_n == 1, "R9", "no re-request", log_n, 1);
  endtask

  task automatic t_bad_offset();
    clear_seq();
    wr(8'h04, w1(1, 1, 0, 5));
    wr(8'h80, w1(1, 1, 0, 5));
    wr(8'h2C, w1(1, 1, 0, 5));
    repeat (10) @(negedge clk);
    #1;
    chk(chan_en == 4'b0, "R2", "misaligned offsets ignored", int'(chan_en), 0);
    chk(log_n == 0, "R2", "no conversion from ignored write", log_n, 0);
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    for (int ch = 0; ch < 4; ch++) t_single_avg(ch, ch, ch * 3 + 2);
    t_single_avg(0, 1, 15);
    t_no_avg();
    t_full_scale();
    t_priority();
    t_continuous();
    t_stop_in_flight();
    t_bad_offset();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule